// File: doc/BRIEF.md
# Overlapping Frame Input Buffer

This block sits between a sample source and a transform engine. It takes a continuous stream of complex samples, one per clock when the source offers one, and cuts it into frames of N points. Successive frames may share part of their content: with no overlap every frame holds N fresh samples, with half overlap each frame keeps the newest N/2 samples of the one before, and with three-quarter overlap it keeps the newest 3N/4. The first frame after reset always needs N samples.

Storage is a circular memory twice the size of the largest frame. New samples are written while a finished frame is streamed out, so the input never waits for the transform. Each finished frame is read out in time order, oldest sample first, one point per clock on a readout port with an index and a last-point marker. Frame length, overlap and real/complex mode are taken from their select pins while the synchronous reset is held. If a frame completes while the previous readout still has more than one point to go, that frame is dropped, the readout in progress is left untouched, and a sticky overrun flag is raised.

Top module: `ovl_frame_buf`

## Requirements
- R1: While `rst` is high at a clock edge, `frm_rdy`, `rd_vld`, `rd_last` and `overrun` are low after that edge, and the counts and pointers return to their start state, so `overrun` is cleared.
- R2: After reset the first frame completes with the N-th accepted sample, where N = 2^LOG2_MAX >> `len_sel` (`len_sel` 0 selects the largest frame). A sample is accepted at a clock edge where `smp_vld` is high.
- R3: After the first frame, a frame completes every H accepted samples. `ovl_sel` 0 gives H = N, 1 gives H = N/2, 2 gives H = N/4, and 3 is treated like 0.
- R4: `frm_rdy` is high for the one cycle after the edge that accepts the completing sample. From the following cycle, `rd_vld` is high for N consecutive cycles with `rd_idx` running 0 to N-1, and `rd_last` is high exactly when `rd_idx` is N-1.
- R5: The point at `rd_idx` = i is accepted sample number T-N+i, where T is the number of samples accepted when the frame completed. Samples are numbered from 0 after reset.
- R6: With `cplx_en` = 0 at reset, only `smp_re` is stored and `rd_im` reads zero. With `cplx_en` = 1, `rd_im` carries `smp_im` of the same sample.
- R7: Samples accepted while a frame is being read out do not change the values that readout delivers.
- R8: A frame that completes fewer than N cycles after the previous `frm_rdy` is dropped: there is no `frm_rdy` for it, the readout in progress continues unchanged, and `overrun` goes high and stays high until reset.
- R9: With no overlap and one sample per cycle, frames follow back to back. `rd_vld` stays high across frame boundaries and `overrun` stays low.
- R10: Changes on `len_sel`, `ovl_sel` and `cplx_en` while `rst` is low have no effect until the next reset.
- R11: Cycles with `smp_vld` low take no sample and do not advance the frame count, whatever is on `smp_re` and `smp_im`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all transfers on its rising edge |
| rst | input | 1 | Synchronous reset, active high; configuration is captured while high |
| len_sel | input | 2 | Frame length select, N = 2^LOG2_MAX >> len_sel |
| ovl_sel | input | 2 | Overlap select: 0 none, 1 half, 2 three-quarter, 3 none |
| cplx_en | input | 1 | 1 stores the imaginary input, 0 stores zero imaginary parts |
| smp_vld | input | 1 | Sample strobe |
| smp_re | input | DW | Real part of the sample |
| smp_im | input | DW | Imaginary part of the sample |
| frm_rdy | output | 1 | One-cycle pulse when a frame is accepted for readout |
| rd_vld | output | 1 | Readout point valid |
| rd_re | output | DW | Readout real part |
| rd_im | output | DW | Readout imaginary part |
| rd_idx | output | LOG2_MAX | Position of the readout point in its frame |
| rd_last | output | 1 | Marks the final point of a frame |
| overrun | output | 1 | Sticky flag: a completed frame was dropped |

## Verification
The bench builds the block with LOG2_MAX = 5, DW = 16 and split real/imaginary storage. This makes the four frame lengths 32, 16, 8 and 4, so that every length select, every overlap setting and the reserved overlap code can be run to several frames within a few hundred cycles. Short frames also make the hop as small as two samples. That brings the dropped-frame case into reach: input at full rate outruns the readout, while sparser input paced to exactly N cycles per hop just avoids an overrun. A reference model in the bench predicts every frame boundary and every readout point from the sample count alone.

// File: rtl/ofb_pkg.sv
package ofb_pkg;

   typedef enum logic [1:0] {
      OVL_NONE  = 2'd0,
      OVL_HALF  = 2'd1,
      OVL_QUART = 2'd2,
      OVL_RSVD  = 2'd3
   } ovl_mode_e;

   // Right shift applied to the frame length to obtain the hop size.
   function automatic int hop_shift(ovl_mode_e m);
      case (m)
         OVL_HALF:  return 1;
         OVL_QUART: return 2;
         default:   return 0;
      endcase
   endfunction

endpackage

// File: rtl/ofb_store.sv
module ofb_store #(
   parameter int AW        = 11,
   parameter int DW        = 16,
   parameter bit SPLIT_MEM = 1'b1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wre,
   input  logic [DW-1:0] wim,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rre,
   output logic [DW-1:0] rim
);
   localparam int DEPTH = 1 << AW;

   generate
      if (SPLIT_MEM) begin : g_split
         logic [DW-1:0] mem_re [DEPTH];
         logic [DW-1:0] mem_im [DEPTH];
         always_ff @(posedge clk) begin
            if (we) begin
               mem_re[waddr] <= wre;
               mem_im[waddr] <= wim;
            end
            rre <= mem_re[raddr];
            rim <= mem_im[raddr];
         end
      end else begin : g_packed
         logic [2*DW-1:0] mem [DEPTH];
         logic [2*DW-1:0] q;
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= {wre, wim};
            q <= mem[raddr];
         end
         assign rre = q[2*DW-1:DW];
         assign rim = q[DW-1:0];
      end
   endgenerate
endmodule

// File: rtl/ofb_wrctl.sv
module ofb_wrctl #(
   parameter int LOG2_MAX = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_req,
   input  logic [LOG2_MAX:0] n_len,
   input  logic [LOG2_MAX:0] hop,
   output logic [LOG2_MAX:0] wr_ptr,
   output logic              commit,
   output logic [LOG2_MAX:0] base
);
   localparam int LW = LOG2_MAX + 1;

   logic [LW-1:0] cnt;
   logic [LW-1:0] thr;
   logic          primed;

   assign thr    = primed ? hop : n_len;
   assign commit = wr_req && ((cnt + 1'b1) == thr);
   // oldest retained sample of the frame closed by this write
   assign base   = wr_ptr + 1'b1 - n_len;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         primed <= 1'b0;
         wr_ptr <= '0;
      end else if (wr_req) begin
         wr_ptr <= wr_ptr + 1'b1;
         if (commit) begin
            cnt    <= '0;
            primed <= 1'b1;
         end else begin
            cnt    <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ofb_rdctl.sv
module ofb_rdctl #(
   parameter int LOG2_MAX = 10
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                commit,
   input  logic [LOG2_MAX:0]   base_in,
   input  logic [LOG2_MAX:0]   n_len,
   output logic [LOG2_MAX:0]   rd_addr,
   output logic                frm_rdy,
   output logic                o_vld,
   output logic [LOG2_MAX-1:0] o_idx,
   output logic                o_last,
   output logic                overrun
);
   logic                busy;
   logic [LOG2_MAX-1:0] ridx;
   logic [LOG2_MAX:0]   base;
   logic                fin;
   logic                take;

   assign fin     = busy && ({1'b0, ridx} == (n_len - 1'b1));
   assign take    = commit && (!busy || fin);
   assign rd_addr = base + {1'b0, ridx};

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         ridx    <= '0;
         base    <= '0;
         frm_rdy <= 1'b0;
         overrun <= 1'b0;
         o_vld   <= 1'b0;
         o_idx   <= '0;
         o_last  <= 1'b0;
      end else begin
         frm_rdy <= take;
         if (commit && !take) overrun <= 1'b1;
         if (take) begin
            busy <= 1'b1;
            ridx <= '0;
            base <= base_in;
         end else if (busy) begin
            if (fin) busy <= 1'b0;
            else     ridx <= ridx + 1'b1;
         end
         // aligned with the registered memory read
         o_vld  <= busy;
         o_idx  <= ridx;
         o_last <= fin;
      end
   end
endmodule

// File: rtl/ovl_frame_buf.sv
module ovl_frame_buf #(
   parameter int LOG2_MAX  = 10,
   parameter int DW        = 16,
   parameter bit SPLIT_MEM = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [1:0]          len_sel,
   input  logic [1:0]          ovl_sel,
   input  logic                cplx_en,
   input  logic                smp_vld,
   input  logic [DW-1:0]       smp_re,
   input  logic [DW-1:0]       smp_im,
   output logic                frm_rdy,
   output logic                rd_vld,
   output logic [DW-1:0]       rd_re,
   output logic [DW-1:0]       rd_im,
   output logic [LOG2_MAX-1:0] rd_idx,
   output logic                rd_last,
   output logic                overrun
);
   import ofb_pkg::*;

   localparam int LW   = LOG2_MAX + 1;
   localparam int AW   = LOG2_MAX + 1;
   localparam int MAXN = 1 << LOG2_MAX;

   generate
      if (LOG2_MAX < 3 || LOG2_MAX > 14) begin : g_bad_len
         $error("ovl_frame_buf: LOG2_MAX must lie in 3..14");
      end
      if (DW < 1) begin : g_bad_dw
         $error("ovl_frame_buf: DW must be positive");
      end
   endgenerate

   logic [1:0]    len_q;
   ovl_mode_e     ovl_q;
   logic          cplx_q;
   logic [LW-1:0] n_len;
   logic [LW-1:0] hop;
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] base;
   logic [AW-1:0] rd_addr;
   logic          commit;
   logic [DW-1:0] wim;

   // configuration is frozen outside reset
   always_ff @(posedge clk) begin
      if (rst) begin
         len_q  <= len_sel;
         ovl_q  <= ovl_mode_e'(ovl_sel);
         cplx_q <= cplx_en;
      end
   end

   assign n_len = LW'(MAXN) >> len_q;
   assign hop   = n_len >> hop_shift(ovl_q);
   assign wim   = cplx_q ? smp_im : '0;

   ofb_wrctl #(.LOG2_MAX(LOG2_MAX)) u_wr (
      .clk    (clk),
      .rst    (rst),
      .wr_req (smp_vld),
      .n_len  (n_len),
      .hop    (hop),
      .wr_ptr (wr_ptr),
      .commit (commit),
      .base   (base)
   );

   ofb_rdctl #(.LOG2_MAX(LOG2_MAX)) u_rd (
      .clk     (clk),
      .rst     (rst),
      .commit  (commit),
      .base_in (base),
      .n_len   (n_len),
      .rd_addr (rd_addr),
      .frm_rdy (frm_rdy),
      .o_vld   (rd_vld),
      .o_idx   (rd_idx),
      .o_last  (rd_last),
      .overrun (overrun)
   );

   ofb_store #(.AW(AW), .DW(DW), .SPLIT_MEM(SPLIT_MEM)) u_mem (
      .clk   (clk),
      .we    (smp_vld),
      .waddr (wr_ptr),
      .wre   (smp_re),
      .wim   (wim),
      .raddr (rd_addr),
      .rre   (rd_re),
      .rim   (rd_im)
   );
endmodule

// File: rtl/ovl_frame_buf_chk.sv
module ovl_frame_buf_chk #(
   parameter int LOG2_MAX = 10,
   parameter int DW       = 16
) (
   input logic                clk,
   input logic                rst,
   input logic [1:0]          len_sel,
   input logic                cplx_en,
   input logic                frm_rdy,
   input logic                rd_vld,
   input logic [LOG2_MAX-1:0] rd_idx,
   input logic                rd_last,
   input logic [DW-1:0]       rd_im,
   input logic                overrun
);
   localparam int LW   = LOG2_MAX + 1;
   localparam int MAXN = 1 << LOG2_MAX;

   logic [1:0]    len_c;
   logic          cplx_c;
   logic [LW-1:0] n_c;

   always_ff @(posedge clk) begin
      if (rst) begin
         len_c  <= len_sel;
         cplx_c <= cplx_en;
      end
   end
   assign n_c = LW'(MAXN) >> len_c;

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (!frm_rdy && !rd_vld && !rd_last && !overrun));

   assert_first_point_R4: assert property (@(posedge clk) disable iff (rst)
      frm_rdy |=> (rd_vld && rd_idx == '0));

   assert_idx_step_R4: assert property (@(posedge clk) disable iff (rst)
      (rd_vld && !rd_last) |=> (rd_vld && rd_idx == $past(rd_idx) + 1'b1));

   assert_last_position_R4: assert property (@(posedge clk) disable iff (rst)
      rd_last |-> (rd_vld && ({1'b0, rd_idx} == n_c - 1'b1)));

   assert_real_mode_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_vld && !cplx_c) |-> (rd_im == '0));

   assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      overrun |=> overrun);

   assert_no_ready_midframe_R8: assert property (@(posedge clk) disable iff (rst)
      (rd_vld && !rd_last) |-> !frm_rdy);
endmodule

bind ovl_frame_buf ovl_frame_buf_chk #(.LOG2_MAX(LOG2_MAX), .DW(DW)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .len_sel (len_sel),
   .cplx_en (cplx_en),
   .frm_rdy (frm_rdy),
   .rd_vld  (rd_vld),
   .rd_idx  (rd_idx),
   .rd_last (rd_last),
   .rd_im   (rd_im),
   .overrun (overrun)
);

// File: tb/sim_ovl_frame_buf.sv
`timescale 1ns/1ps
module sim_ovl_frame_buf;
   localparam int LOG2_MAX = 5;
   localparam int DW       = 16;
   localparam int MAXN     = 1 << LOG2_MAX;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic [1:0]          len_sel = '0;
   logic [1:0]          ovl_sel = '0;
   logic                cplx_en = 1'b1;
   logic                smp_vld = 1'b0;
   logic [DW-1:0]       smp_re = '0;
   logic [DW-1:0]       smp_im = '0;
   logic                frm_rdy, rd_vld, rd_last, overrun;
   logic [DW-1:0]       rd_re, rd_im;
   logic [LOG2_MAX-1:0] rd_idx;

   ovl_frame_buf #(.LOG2_MAX(LOG2_MAX), .DW(DW), .SPLIT_MEM(1'b1)) u0 (
      .clk(clk), .rst(rst), .len_sel(len_sel), .ovl_sel(ovl_sel),
      .cplx_en(cplx_en), .smp_vld(smp_vld), .smp_re(smp_re), .smp_im(smp_im),
      .frm_rdy(frm_rdy), .rd_vld(rd_vld), .rd_re(rd_re), .rd_im(rd_im),
      .rd_idx(rd_idx), .rd_last(rd_last), .overrun(overrun)
   );

   always #4 clk = ~clk;

   int nchk = 0;
   int nerr = 0;

   task automatic chk(bit ok, string tag, int act, int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] f_re(int s);
      return DW'(s * 7 + 4369);
   endfunction
   function automatic logic [DW-1:0] f_im(int s);
      return DW'(s) ^ 16'hA000;
   endfunction

   // reference model state
   int run = 0, cyc = 0, m_n = 0, m_h = 0, m_cplx = 0;
   int mcnt = 0, thr = 0, has_last = 0, last = 0, start = 0, eovr = 0;
   int pending = 0, taken = 0, sent = 0, nsmp = 0, gap = 0, idle = 0, seen = 0;

   always @(negedge clk) begin
      if (run != 0) begin
         int idx, erdy;
         bit ev;
         cyc++;
         // readout expectation for the frame already under way
         ev = (has_last != 0) && (cyc > last) && (cyc <= last + m_n);
         chk(rd_vld == ev, "R4 rd_vld", int'(rd_vld), int'(ev));
         if (ev && rd_vld) begin
            idx = cyc - last - 1;
            chk(int'(rd_idx) == idx, "R4 rd_idx", int'(rd_idx), idx);
            chk(rd_last == (idx == m_n - 1), "R4 rd_last", int'(rd_last), int'(idx == m_n - 1));
            chk(rd_re == f_re(start + idx), "R5 R7 rd_re", int'(rd_re), int'(f_re(start + idx)));
            chk(rd_im == ((m_cplx != 0) ? f_im(start + idx) : '0), "R6 rd_im",
                int'(rd_im), (m_cplx != 0) ? int'(f_im(start + idx)) : 0);
         end
         // sample taken at the edge just passed
         erdy = 0;
         if (pending != 0) begin
            pending = 0;
            taken++;
            mcnt++;
            if (mcnt == thr) begin
               mcnt = 0;
               thr  = m_h;
               if (has_last == 0 || cyc - last >= m_n) begin
                  erdy = 1; has_last = 1; last = cyc; start = taken - m_n;
               end else begin
                  eovr = 1;
               end
            end
         end
         chk(int'(frm_rdy) == erdy, "R2 R3 frm_rdy", int'(frm_rdy), erdy);
         if (frm_rdy) seen++;
         chk(int'(overrun) == eovr, "R8 overrun", int'(overrun), eovr);
         // drive next input; R11 garbage when idle
         if (sent < nsmp && idle == 0) begin
            smp_vld = 1'b1;
            smp_re  = f_re(sent);
            smp_im  = f_im(sent);
            sent++;
            pending = 1;
            idle    = gap;
         end else begin
            smp_vld = 1'b0;
            smp_re  = DW'(cyc * 13 + 5);
            smp_im  = ~DW'(cyc * 13 + 5);
            if (idle > 0) idle--;
         end
      end
   end

   task automatic do_reset(int l, int o, int c);
      @(posedge clk); #1;
      run = 0; rst = 1'b1; smp_vld = 1'b0;
      len_sel = 2'(l); ovl_sel = 2'(o); cplx_en = c[0];
      repeat (2) @(posedge clk);
      #1;
      chk(!frm_rdy && !rd_vld && !rd_last && !overrun, "R1 reset outputs",
          int'({frm_rdy, rd_vld, rd_last, overrun}), 0);
      rst = 1'b0;
      m_n = MAXN >> l;
      m_h = (o == 1) ? m_n / 2 : (o == 2) ? m_n / 4 : m_n;
      m_cplx = c; mcnt = 0; thr = m_n; has_last = 0; last = 0; start = 0;
      eovr = 0; pending = 0; taken = 0; sent = 0; nsmp = 0; gap = 0;
      idle = 0; seen = 0; cyc = 0;
      run = 1;
   endtask

   task automatic run_stream(int n, int g);
      gap = g; nsmp = n;
      while (sent < n) @(posedge clk);
      repeat (m_n + 6) @(posedge clk);
      #1;
   endtask

   // len_sel, ovl_sel, cplx_en, gap, samples, frames, overrun
   localparam int SCN [6][7] = '{
      '{0, 0, 1, 0, 96, 3, 0},
      '{1, 1, 1, 1, 48, 5, 0},
      '{2, 2, 0, 3, 20, 7, 0},
      '{1, 1, 1, 0, 48, 3, 1},
      '{3, 3, 1, 0, 12, 3, 0},
      '{2, 2, 0, 0, 24, 3, 1}
   };

   initial begin
      repeat (3) @(posedge clk);
      for (int i = 0; i < 6; i++) begin
         do_reset(SCN[i][0], SCN[i][1], SCN[i][2]);
         run_stream(SCN[i][4], SCN[i][3]);
         chk(seen == SCN[i][5], "R3 R8 R9 frame count", seen, SCN[i][5]);
         chk(int'(overrun) == SCN[i][6], "R8 R9 final overrun", int'(overrun), SCN[i][6]);
      end
      // R1: a set overrun is cleared by reset
      do_reset(3, 0, 1);
      chk(!overrun, "R1 overrun cleared", int'(overrun), 0);
      // R11: idle cycles with changing data take nothing
      repeat (30) @(posedge clk);
      #1;
      chk(seen == 0 && !rd_vld, "R11 idle input", seen, 0);
      run_stream(4, 0);
      chk(seen == 1, "R2 first frame after N samples", seen, 1);
      // R10: select changes after reset are ignored
      do_reset(2, 0, 1);
      len_sel = 2'd0; ovl_sel = 2'd1; cplx_en = 1'b0;
      run_stream(16, 0);
      chk(seen == 2, "R10 config held", seen, 2);
      chk(!overrun, "R10 no overrun", int'(overrun), 0);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule